// File: doc/BRIEF.md
# DMA Request Routing Multiplexer

This block sits between the request lines of the peripherals and the channels of a DMA controller. Each output channel has its own source select. The select can name any peripheral request line or any output of a shared request generator. The controller's acknowledge for the channel is steered back to the source that channel has picked. Every channel can pass its chosen request straight through. It can also hold the request back until a chosen synchronization source shows a rising edge. After that edge it lets a programmed number of transfers through and then closes again.

The request generator has several independent lines. Each line watches a selectable trigger. On a rising edge it raises a DMA request and keeps it raised for a programmed number of acknowledged transfers. Each output channel also produces a one-cycle event pulse when its programmed batch of transfers has completed. Both the sync selects and the trigger selects can pick these events. One channel can therefore pace another channel or start a generator line. All configuration arrives as static input vectors. The register decoding is done outside this block.

Top module: `dma_req_router`

## Requirements
- R1: Channel c forwards the source named by its ch_src_sel field (bits c*SRC_W upward): value s below NUM_PERIPH picks periph_req[s], value s from NUM_PERIPH to NUM_PERIPH+NUM_GEN-1 picks generator line s-NUM_PERIPH, and any larger value picks no source (request stays low).
- R2: With ch_sync_mode[c]=0 (free mode) and the channel enabled, ch_req[c] follows the selected source in the same cycle.
- R3: An acknowledge on ch_ack[c] while ch_req[c] is high is returned in the same cycle on the acknowledge of the selected source (periph_ack bit for a peripheral, the generator line otherwise).
- R4: While ch_enable[c]=0, ch_req[c] and ch_evt[c] stay low whatever the source does, and the gate and transfer count of that channel are cleared.
- R5: With ch_sync_mode[c]=1 the gate starts closed; a rising edge on the selected sync source opens it from the next cycle, and it closes again after ch_req_cnt+1 acknowledged transfers. Sync select value v below NUM_SYNC picks sync_in[v]; value v at or above NUM_SYNC picks ch_evt[v-NUM_SYNC].
- R6: ch_evt[c] is high for exactly one cycle, the cycle after the acknowledge that completes transfer number ch_req_cnt+1 of the batch. This holds in both modes, and in free mode the count restarts after each event.
- R7: An enabled, idle generator line g raises its request one cycle after a rising edge on its selected trigger. Trigger select value v below NUM_TRIG picks gen_trig[v]; a larger value picks ch_evt[v-NUM_TRIG]. The request stays high until gen_req_cnt+1 acknowledges have been returned to it, and then it drops.
- R8: A generator line ignores trigger edges while its request is active. A trigger held at a steady level does not restart the line. A disabled line keeps its request low and ignores its trigger.
- R9: The event of one channel, chosen as the sync source of another channel, opens that channel's gate one cycle after the event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_req | input | NUM_PERIPH | Request lines from peripherals |
| periph_ack | output | NUM_PERIPH | Acknowledge returned to peripherals |
| gen_trig | input | NUM_TRIG | Trigger inputs for generator lines |
| sync_in | input | NUM_SYNC | External synchronization inputs |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_src_sel | input | NUM_CH*SRC_W | Per-channel request source select |
| ch_sync_mode | input | NUM_CH | Per-channel mode: 0 free, 1 synchronized |
| ch_sync_sel | input | NUM_CH*SYNC_SEL_W | Per-channel sync source select |
| ch_req_cnt | input | NUM_CH*CNT_W | Per-channel batch size minus one |
| gen_enable | input | NUM_GEN | Per-generator-line enable |
| gen_trig_sel | input | NUM_GEN*TRIG_SEL_W | Per-line trigger select |
| gen_req_cnt | input | NUM_GEN*CNT_W | Per-line request count minus one |
| ch_ack | input | NUM_CH | Acknowledge from controller channels |
| ch_req | output | NUM_CH | Requests forwarded to controller channels |
| ch_evt | output | NUM_CH | One-cycle batch-complete event per channel |

## Verification
A corrupt transfer count in a channel shows at the ports as an event pulse and a gate closure that come one or more acknowledges early or late. This is visible in the cycle after the wrong acknowledge. A gate that is wrongly left open or shut shows on ch_req in the first cycle where the source is high. A generator line whose remaining count is off shows as a request that drops too soon or stays up after its last acknowledge. An edge detector that is stuck or missing restarts a line from a level, or never starts it. Each of these faults is therefore visible within one or two cycles of the event that exposes it.

// File: rtl/dmarr_pkg.sv
// Shared types for the DMA request router.
// Assumes: nothing beyond being compiled before the modules that import it.
package dmarr_pkg;

    // Forwarding mode of one output channel.
    typedef enum logic {
        FWD_FREE = 1'b0,
        FWD_SYNC = 1'b1
    } fwd_mode_e;

endpackage

// File: rtl/dmarr_sel.sv
// Index selector: returns bit 'sel_i' of 'vec_i', or 0 when the index is
// past the end of the vector.
// Assumes: SEL_W is wide enough to address all N entries.
module dmarr_sel #(
    parameter int N     = 8,
    parameter int SEL_W = 3
) (
    input  logic [N-1:0]     vec_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             bit_o
);

    // Compare the index against every position; out-of-range gives 0.
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sel_i == SEL_W'(i)) begin
                bit_o = vec_i[i];
            end
        end
    end

endmodule

// File: rtl/dmarr_req_gen.sv
// One request-generator line: a rising edge on the trigger raises a DMA
// request that is held for cnt_i+1 acknowledged transfers.
// Assumes: ack_i is only meaningful while req_o is high; cnt_i is stable
// while a burst is running.
module dmarr_req_gen #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ack_i,
    output logic             req_o
);

    logic             trig_q;
    logic             req_q;
    logic [CNT_W-1:0] rem_q;
    logic             trig_edge;

    assign trig_edge = trig_i & ~trig_q;
    assign req_o     = req_q;

    // Remember the previous trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig_i;
        end
    end

    // Start a burst on an idle edge; count acknowledges down to the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            rem_q <= '0;
        end else if (!en_i) begin
            req_q <= 1'b0;
            rem_q <= '0;
        end else if (!req_q) begin
            if (trig_edge) begin
                req_q <= 1'b1;
                rem_q <= cnt_i;
            end
        end else if (ack_i) begin
            if (rem_q == '0) begin
                req_q <= 1'b0;
            end else begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    // R7: an unacknowledged request stays raised on the next cycle
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && req_o && !ack_i) |=> req_o);

    // R7: a request only rises after the trigger was seen high
    a_r7_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(trig_i));

    // R8: a disabled line has no request on the following cycle
    a_r8_disabled_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !req_o);

endmodule

// File: rtl/dmarr_sync_unit.sv
// Per-channel forwarding stage. In free mode the selected request passes
// straight through. In sync mode it passes only while a gate is open. A
// sync rising edge opens the gate, and the gate closes after cnt_i+1
// acknowledged transfers. The stage emits a one-cycle event when a batch
// completes.
// Assumes: mode_i and cnt_i are changed only while the channel is disabled.
module dmarr_sync_unit
    import dmarr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             mode_i,
    input  logic             src_req_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic             evt_o
);

    logic             sync_q;
    logic             gate_q;
    logic             evt_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_sync;
    logic             sync_edge;
    logic             done;

    assign is_sync   = (mode_i == FWD_SYNC);
    assign sync_edge = sync_i & ~sync_q;
    assign req_o     = en_i & (gate_q | ~is_sync) & src_req_i;
    assign done      = req_o & ack_i;
    assign evt_o     = evt_q;

    // Remember the previous sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else begin
            sync_q <= sync_i;
        end
    end

    // Gate control, batch counting and event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            cnt_q  <= '0;
            evt_q  <= 1'b0;
        end else if (!en_i) begin
            gate_q <= 1'b0;
            cnt_q  <= '0;
            evt_q  <= 1'b0;
        end else if (is_sync && sync_edge) begin
            gate_q <= 1'b1;
            cnt_q  <= '0;
            evt_q  <= 1'b0;
        end else if (done) begin
            if (cnt_q == cnt_i) begin
                gate_q <= 1'b0;
                cnt_q  <= '0;
                evt_q  <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                evt_q  <= 1'b0;
            end
        end else begin
            evt_q <= 1'b0;
        end
    end

    // R4: a disabled channel never forwards a request
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !req_o);

    // R6: an event pulse only follows an acknowledged transfer
    a_r6_evt_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(done));

    // R5: in sync mode the gate is shut when the batch event appears
    a_r5_closed_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && is_sync && evt_o) |-> !req_o);

endmodule

// File: rtl/dma_req_router.sv
// DMA request router: per-channel source select over peripheral and
// generator requests, per-channel sync gating and batch events, a shared
// multi-line request generator, and acknowledge steering back to sources.
// Assumes: configuration inputs are quasi-static, and events are used as
// sync or trigger sources only through the registered event outputs.
module dma_req_router #(
    parameter int  NUM_PERIPH = 8,
    parameter int  NUM_GEN    = 4,
    parameter int  NUM_CH     = 4,
    parameter int  NUM_SYNC   = 4,
    parameter int  NUM_TRIG   = 4,
    parameter int  CNT_W      = 4,
    localparam int NUM_SRC    = NUM_PERIPH + NUM_GEN,
    localparam int SRC_W      = $clog2(NUM_SRC + 1),
    localparam int SYNC_SEL_W = $clog2(NUM_SYNC + NUM_CH),
    localparam int TRIG_SEL_W = $clog2(NUM_TRIG + NUM_CH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PERIPH-1:0]        periph_req,
    output logic [NUM_PERIPH-1:0]        periph_ack,
    input  logic [NUM_TRIG-1:0]          gen_trig,
    input  logic [NUM_SYNC-1:0]          sync_in,
    input  logic [NUM_CH-1:0]            ch_enable,
    input  logic [NUM_CH*SRC_W-1:0]      ch_src_sel,
    input  logic [NUM_CH-1:0]            ch_sync_mode,
    input  logic [NUM_CH*SYNC_SEL_W-1:0] ch_sync_sel,
    input  logic [NUM_CH*CNT_W-1:0]      ch_req_cnt,
    input  logic [NUM_GEN-1:0]           gen_enable,
    input  logic [NUM_GEN*TRIG_SEL_W-1:0] gen_trig_sel,
    input  logic [NUM_GEN*CNT_W-1:0]     gen_req_cnt,
    input  logic [NUM_CH-1:0]            ch_ack,
    output logic [NUM_CH-1:0]            ch_req,
    output logic [NUM_CH-1:0]            ch_evt
);

    logic [NUM_GEN-1:0]         gen_req;
    logic [NUM_GEN-1:0]         gen_ack;
    logic [NUM_SRC-1:0]         src_req;
    logic [NUM_SRC-1:0]         src_ack;
    logic [NUM_SYNC+NUM_CH-1:0] sync_pool;
    logic [NUM_TRIG+NUM_CH-1:0] trig_pool;

    assign src_req   = {gen_req, periph_req};
    assign sync_pool = {ch_evt, sync_in};
    assign trig_pool = {ch_evt, gen_trig};

    // Steer each completed acknowledge back to the source its channel picked.
    always_comb begin
        src_ack = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (ch_req[c] && ch_ack[c] &&
                    (ch_src_sel[c*SRC_W +: SRC_W] == SRC_W'(s))) begin
                    src_ack[s] = 1'b1;
                end
            end
        end
    end

    assign periph_ack = src_ack[NUM_PERIPH-1:0];
    assign gen_ack    = src_ack[NUM_SRC-1:NUM_PERIPH];

    // Shared request generator, one line per generate iteration.
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        logic trig_sel_bit;

        dmarr_sel #(
            .N     (NUM_TRIG + NUM_CH),
            .SEL_W (TRIG_SEL_W)
        ) u_trig_sel (
            .vec_i (trig_pool),
            .sel_i (gen_trig_sel[g*TRIG_SEL_W +: TRIG_SEL_W]),
            .bit_o (trig_sel_bit)
        );

        dmarr_req_gen #(
            .CNT_W (CNT_W)
        ) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (gen_enable[g]),
            .trig_i (trig_sel_bit),
            .cnt_i  (gen_req_cnt[g*CNT_W +: CNT_W]),
            .ack_i  (gen_ack[g]),
            .req_o  (gen_req[g])
        );
    end

    // Output channels: source select, sync select and forwarding stage.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic src_bit;
        logic sync_bit;

        dmarr_sel #(
            .N     (NUM_SRC),
            .SEL_W (SRC_W)
        ) u_src_sel (
            .vec_i (src_req),
            .sel_i (ch_src_sel[c*SRC_W +: SRC_W]),
            .bit_o (src_bit)
        );

        dmarr_sel #(
            .N     (NUM_SYNC + NUM_CH),
            .SEL_W (SYNC_SEL_W)
        ) u_sync_sel (
            .vec_i (sync_pool),
            .sel_i (ch_sync_sel[c*SYNC_SEL_W +: SYNC_SEL_W]),
            .bit_o (sync_bit)
        );

        dmarr_sync_unit #(
            .CNT_W (CNT_W)
        ) u_fwd (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (ch_enable[c]),
            .mode_i    (ch_sync_mode[c]),
            .src_req_i (src_bit),
            .sync_i    (sync_bit),
            .cnt_i     (ch_req_cnt[c*CNT_W +: CNT_W]),
            .ack_i     (ch_ack[c]),
            .req_o     (ch_req[c]),
            .evt_o     (ch_evt[c])
        );
    end

    // R3: an acknowledge reaches a peripheral only while some channel requests
    a_r3_ack_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_ack) |-> (|(ch_req & ch_ack)));

endmodule

// File: tb/dma_req_router_tb.sv
// Directed bench for the DMA request router: one task per scenario.
module dma_req_router_tb_top;

    localparam int NP = 8;
    localparam int NG = 4;
    localparam int NC = 4;
    localparam int NS = 4;
    localparam int NT = 4;
    localparam int CW = 4;
    localparam int SW = 4;   // source select width
    localparam int YW = 3;   // sync select width
    localparam int TW = 3;   // trigger select width

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NP-1:0]      periph_req;
    logic [NP-1:0]      periph_ack;
    logic [NT-1:0]      gen_trig;
    logic [NS-1:0]      sync_in;
    logic [NC-1:0]      ch_enable;
    logic [NC*SW-1:0]   ch_src_sel;
    logic [NC-1:0]      ch_sync_mode;
    logic [NC*YW-1:0]   ch_sync_sel;
    logic [NC*CW-1:0]   ch_req_cnt;
    logic [NG-1:0]      gen_enable;
    logic [NG*TW-1:0]   gen_trig_sel;
    logic [NG*CW-1:0]   gen_req_cnt;
    logic [NC-1:0]      ch_ack;
    logic [NC-1:0]      ch_req;
    logic [NC-1:0]      ch_evt;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    dma_req_router dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .periph_req   (periph_req),
        .periph_ack   (periph_ack),
        .gen_trig     (gen_trig),
        .sync_in      (sync_in),
        .ch_enable    (ch_enable),
        .ch_src_sel   (ch_src_sel),
        .ch_sync_mode (ch_sync_mode),
        .ch_sync_sel  (ch_sync_sel),
        .ch_req_cnt   (ch_req_cnt),
        .gen_enable   (gen_enable),
        .gen_trig_sel (gen_trig_sel),
        .gen_req_cnt  (gen_req_cnt),
        .ch_ack       (ch_ack),
        .ch_req       (ch_req),
        .ch_evt       (ch_evt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic set_ch(input int c, input logic en, input logic [SW-1:0] src,
                          input logic mode, input logic [YW-1:0] ysel,
                          input logic [CW-1:0] cnt);
        ch_enable[c]              = en;
        ch_src_sel[c*SW +: SW]    = src;
        ch_sync_mode[c]           = mode;
        ch_sync_sel[c*YW +: YW]   = ysel;
        ch_req_cnt[c*CW +: CW]    = cnt;
    endtask

    task automatic set_gen(input int g, input logic en, input logic [TW-1:0] tsel,
                           input logic [CW-1:0] cnt);
        gen_enable[g]             = en;
        gen_trig_sel[g*TW +: TW]  = tsel;
        gen_req_cnt[g*CW +: CW]   = cnt;
    endtask

    task automatic apply_reset();
        periph_req   = '0;
        gen_trig     = '0;
        sync_in      = '0;
        ch_enable    = '0;
        ch_src_sel   = '0;
        ch_sync_mode = '0;
        ch_sync_sel  = '0;
        ch_req_cnt   = '0;
        gen_enable   = '0;
        gen_trig_sel = '0;
        gen_req_cnt  = '0;
        ch_ack       = '0;
        rst_n        = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    // Reset state: nothing requested, acknowledged or signalled.
    task automatic t_reset();
        apply_reset();
        chk("R4 reset ch_req", 32'(ch_req), 32'h0);
        chk("R6 reset ch_evt", 32'(ch_evt), 32'h0);
        chk("R3 reset periph_ack", 32'(periph_ack), 32'h0);
    endtask

    // Free-mode routing, acknowledge steering and select range.
    task automatic t_free_route();
        apply_reset();
        set_ch(0, 1'b1, 4'd3, 1'b0, 3'd0, 4'd0);
        periph_req = 8'h08;
        #1;
        chk("R2 free pass-through high", 32'(ch_req[0]), 32'h1);
        periph_req = 8'hF7;
        #1;
        chk("R1 other lines ignored", 32'(ch_req[0]), 32'h0);
        periph_req = 8'h08;
        ch_ack[0]  = 1'b1;
        #1;
        chk("R3 ack returned to periph 3", 32'(periph_ack), 32'h08);
        ch_ack[0]  = 1'b0;
        set_ch(0, 1'b1, 4'd9, 1'b0, 3'd0, 4'd0);
        periph_req = 8'hFF;
        #1;
        chk("R1 idle generator selected", 32'(ch_req[0]), 32'h0);
        set_ch(0, 1'b1, 4'd15, 1'b0, 3'd0, 4'd0);
        #1;
        chk("R1 out-of-range select", 32'(ch_req[0]), 32'h0);
        step();
    endtask

    // Disabled channel stays quiet whatever the source does.
    task automatic t_disabled();
        apply_reset();
        set_ch(1, 1'b0, 4'd1, 1'b0, 3'd0, 4'd0);
        periph_req = 8'hFF;
        ch_ack[1]  = 1'b1;
        step();
        chk("R4 disabled ch_req", 32'(ch_req[1]), 32'h0);
        chk("R4 disabled periph_ack", 32'(periph_ack), 32'h0);
        step();
        chk("R4 disabled no event", 32'(ch_evt[1]), 32'h0);
        ch_ack[1] = 1'b0;
    endtask

    // Sync gating: edge opens the gate for cnt+1 transfers, then an event.
    task automatic t_sync_gate();
        apply_reset();
        set_ch(1, 1'b1, 4'd2, 1'b1, 3'd0, 4'd2);
        periph_req = 8'h04;
        step();
        chk("R5 gate closed before sync", 32'(ch_req[1]), 32'h0);
        sync_in[0] = 1'b1;
        step();
        sync_in[0] = 1'b0;
        chk("R5 gate open after sync edge", 32'(ch_req[1]), 32'h1);
        for (int k = 0; k < 3; k++) begin
            ch_ack[1] = 1'b1;
            #1;
            if (k == 0) chk("R3 ack steered in sync mode", 32'(periph_ack), 32'h04);
            step();
            ch_ack[1] = 1'b0;
            #1;
            if (k < 2) begin
                chk("R6 no event mid-batch", 32'(ch_evt[1]), 32'h0);
                chk("R5 gate still open", 32'(ch_req[1]), 32'h1);
            end else begin
                chk("R6 event after last transfer", 32'(ch_evt[1]), 32'h1);
                chk("R5 gate closed after batch", 32'(ch_req[1]), 32'h0);
            end
        end
        sync_in[0] = 1'b1;
        step();
        chk("R6 event lasts one cycle", 32'(ch_evt[1]), 32'h0);
        chk("R5 reopened by new edge", 32'(ch_req[1]), 32'h1);
        step();
        step();
        chk("R5 steady sync level keeps gate", 32'(ch_req[1]), 32'h1);
        sync_in[0] = 1'b0;
    endtask

    // Generator line: trigger edge raises a burst of cnt+1 requests.
    task automatic t_generator();
        apply_reset();
        set_gen(0, 1'b1, 3'd1, 4'd1);
        set_ch(2, 1'b1, 4'd8, 1'b0, 3'd0, 4'd0);
        step();
        chk("R7 no request before trigger", 32'(ch_req[2]), 32'h0);
        gen_trig[1] = 1'b1;
        step();
        chk("R7 request after trigger edge", 32'(ch_req[2]), 32'h1);
        ch_ack[2] = 1'b1;
        step();
        ch_ack[2] = 1'b0;
        #1;
        chk("R7 request kept for second transfer", 32'(ch_req[2]), 32'h1);
        ch_ack[2] = 1'b1;
        step();
        ch_ack[2] = 1'b0;
        #1;
        chk("R7 request dropped after last ack", 32'(ch_req[2]), 32'h0);
        step();
        step();
        chk("R8 held trigger does not restart", 32'(ch_req[2]), 32'h0);
        gen_trig[1] = 1'b0;
    endtask

    // Busy edges are not queued; a disabled line ignores its trigger.
    task automatic t_gen_busy();
        apply_reset();
        set_gen(0, 1'b1, 3'd2, 4'd0);
        set_ch(2, 1'b1, 4'd8, 1'b0, 3'd0, 4'd0);
        gen_trig[2] = 1'b1;
        step();
        gen_trig[2] = 1'b0;
        step();
        gen_trig[2] = 1'b1;
        step();
        chk("R8 request active during busy edge", 32'(ch_req[2]), 32'h1);
        ch_ack[2] = 1'b1;
        step();
        ch_ack[2] = 1'b0;
        #1;
        chk("R8 single request consumed", 32'(ch_req[2]), 32'h0);
        step();
        chk("R8 busy edge not queued", 32'(ch_req[2]), 32'h0);
        set_gen(0, 1'b0, 3'd2, 4'd0);
        gen_trig[2] = 1'b0;
        step();
        gen_trig[2] = 1'b1;
        step();
        chk("R8 disabled line ignores trigger", 32'(ch_req[2]), 32'h0);
        gen_trig[2] = 1'b0;
    endtask

    // Chaining: the event of channel 0 is the sync source of channel 1.
    task automatic t_chain();
        apply_reset();
        set_ch(0, 1'b1, 4'd0, 1'b0, 3'd0, 4'd0);
        set_ch(1, 1'b1, 4'd1, 1'b1, 3'd4, 4'd0);
        periph_req = 8'h03;
        step();
        chk("R9 follower closed before event", 32'(ch_req[1]), 32'h0);
        chk("R2 leader forwards", 32'(ch_req[0]), 32'h1);
        ch_ack[0] = 1'b1;
        step();
        ch_ack[0] = 1'b0;
        #1;
        chk("R6 free-mode event", 32'(ch_evt[0]), 32'h1);
        chk("R9 follower still closed", 32'(ch_req[1]), 32'h0);
        step();
        chk("R9 follower opened by event", 32'(ch_req[1]), 32'h1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails);
        $finish;
    end

    initial begin : main
        t_reset();
        t_free_route();
        t_disabled();
        t_sync_gate();
        t_generator();
        t_gen_busy();
        t_chain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule